// File: doc/BRIEF.md
# SPI Flash Write Guard

This block decides whether a command that alters a 4-Mbit serial flash may run. It owns the write-enable latch and a small status register made of three block-protect bits and a status-write lock bit. A front-end shifter decodes each command. When chip select rises, the shifter presents the command for one cycle together with the target address, the number of serial clock edges it counted, the status data byte and the level of the write-protect pin. The guard checks the command against the latch, the protected region, the hardware lock and the byte alignment of the bit count. One cycle later it answers with either a start pulse to the array engine or a reject pulse.

Commands arrive as a valid-only stream with no ready signal. The guard never applies back-pressure, because each command is resolved in the cycle that follows its valid cycle, and a new command may follow on the next cycle. The array engine reports the end of a program or erase with a one-cycle completion pulse. The guard also exports the decoded protected range, so that the rest of the chip can use it.

Top module: `spi_flash_write_guard`

## Requirements
- R1: After reset, `wel`, `bp`, `srwd`, `go` and `rej` are all 0, and `prot_any` is 0.
- R2: `cmd_op` is encoded as 0 no-op, 1 write-enable, 2 write-disable, 3 status write, 4 page program, 5 sector erase, 6 bulk erase and 7 read. Write-enable sets `wel` and write-disable clears it, on the edge that samples `cmd_valid`. Neither one pulses `go` or `rej`.
- R3: A command of type 3 to 6 issued while `wel` is 0 is rejected.
- R4: A command of type 3 to 6 is rejected unless `cmd_bits` is nonzero and a multiple of eight.
- R5: `bp` drives `prot_any` and `prot_base` as follows. 000 gives no protection. 001 gives a base of 70000h. 010 gives 60000h. 011 gives 40000h. Any code with bit 2 set gives a base of 00000h, which protects the whole array. An address is protected when `prot_any` is 1 and the address is at or above `prot_base`.
- R6: A page program or sector erase to a protected address is rejected. The same command to an address below the base is accepted.
- R7: A bulk erase is rejected whenever `bp` is nonzero.
- R8: While `srwd` is 1 and `wp_n` is 0, a status write is rejected. With `wp_n` at 1, the same status write is accepted.
- R9: An accepted status write loads `bp` from `cmd_data[4:2]` and `srwd` from `cmd_data[7]`, and clears `wel`, all on the edge that samples the command.
- R10: An accepted command of type 3 to 6 raises `go` for one cycle, with `go_op` holding its opcode. After an accepted program or erase, `wel` stays at 1 until `eng_done` pulses, and that pulse clears it. If `eng_done` coincides with a write-enable, the write-enable wins.
- R11: A rejected command raises `rej` for one cycle and leaves `wel`, `bp` and `srwd` unchanged. `go` and `rej` are never high together.
- R12: No-op and read commands change no state and raise neither `go` nor `rej`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle strobe at the chip-select rising edge |
| cmd_op | input | 3 | Decoded opcode (encoding in R2) |
| cmd_addr | input | 19 | Target byte address |
| cmd_bits | input | 16 | Serial clock edges counted while selected |
| cmd_data | input | 8 | Status data byte for a status write |
| wp_n | input | 1 | Write-protect pin level, low active |
| eng_done | input | 1 | Completion pulse from the array engine |
| go | output | 1 | Start pulse for an accepted command |
| go_op | output | 3 | Opcode of the accepted command |
| rej | output | 1 | Reject pulse |
| wel | output | 1 | Write-enable latch |
| bp | output | 3 | Block-protect code |
| srwd | output | 1 | Status-write lock bit |
| prot_any | output | 1 | Some region is protected |
| prot_base | output | 19 | Lowest protected address |

## Verification
The bench runs every protect code against the addresses on each side of the three fractional bases. A decoder with an off-by-one compare, or with a wrong base, would either start a program at 70000h under code 001 or refuse one at 6FFFFh. It also checks that the write-enable latch survives an accepted program and falls only when the completion pulse arrives. A design that cleared it at the start pulse would reject back-to-back work, and a design that ignored the completion pulse would allow a second write without a fresh enable. Bit counts of 0, of a non-multiple of eight and of whole bytes are mixed with the hardware lock and the pin level. A design that loaded status on a rejected write would then show altered protect bits on the following command.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_WREN = 3'd1,
    OP_WRDI = 3'd2,
    OP_WRSR = 3'd3,
    OP_PP   = 3'd4,
    OP_SE   = 3'd5,
    OP_BE   = 3'd6,
    OP_READ = 3'd7
  } wg_op_e;

  function automatic logic op_modifies(wg_op_e op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) || (op == OP_BE);
  endfunction
endpackage

// File: rtl/wg_prot_decode.sv
module wg_prot_decode #(
  parameter int ADDR_W = 19,
  parameter int BP_W   = 3
) (
  input  logic [BP_W-1:0]   bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot_any,
  output logic [ADDR_W-1:0] prot_base,
  output logic              addr_hit
);
  localparam int LVL = 2 ** (BP_W - 1);

  logic [ADDR_W-1:0] base_tbl [LVL];

  // Fractional levels: level g protects the top 2^(g-LVL) of the array.
  for (genvar g = 0; g < LVL; g++) begin : g_base
    if (g == 0) begin : g_none
      assign base_tbl[g] = '0;
    end else begin : g_frac
      localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1) << ADDR_W;
      localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(1) << (ADDR_W - LVL + g);
      localparam logic [ADDR_W:0] DIFF = FULL - SPAN;
      assign base_tbl[g] = DIFF[ADDR_W-1:0];
    end
  end

  always_comb begin
    if (bp[BP_W-1]) begin
      prot_any  = 1'b1;
      prot_base = '0;
    end else if (bp == '0) begin
      prot_any  = 1'b0;
      prot_base = '0;
    end else begin
      prot_any  = 1'b1;
      prot_base = base_tbl[bp[BP_W-2:0]];
    end
  end

  assign addr_hit = prot_any && (addr >= prot_base);
endmodule

// File: rtl/wg_cmd_check.sv
module wg_cmd_check
  import wg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  wg_op_e           op,
  input  logic [CNT_W-1:0] bits,
  input  logic             wel,
  input  logic             srwd,
  input  logic             wp_n,
  input  logic             addr_hit,
  input  logic             bp_nz,
  output logic             is_mod,
  output logic             ok
);
  logic bytes_ok;
  logic hw_lock;

  assign bytes_ok = (bits != '0) && (bits[2:0] == 3'd0);
  assign hw_lock  = srwd && !wp_n;
  assign is_mod   = op_modifies(op);

  always_comb begin
    unique case (op)
      OP_WRSR:      ok = wel && bytes_ok && !hw_lock;
      OP_PP, OP_SE: ok = wel && bytes_ok && !addr_hit;
      OP_BE:        ok = wel && bytes_ok && !bp_nz;
      default:      ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/wg_status_regs.sv
module wg_status_regs #(
  parameter int BP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wel_set,
  input  logic            wel_clr,
  input  logic            sr_load,
  input  logic [BP_W-1:0] bp_in,
  input  logic            srwd_in,
  output logic            wel,
  output logic [BP_W-1:0] bp,
  output logic            srwd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      bp   <= '0;
      srwd <= 1'b0;
    end else begin
      if (wel_set)      wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
      if (sr_load) begin
        bp   <= bp_in;
        srwd <= srwd_in;
      end
    end
  end

  // R10: a clearing event without a set leaves the latch low
  p_wel_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr && !wel_set |=> !wel);
  // R11: status bits only move on a load
  p_sr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_load |=> $stable(bp) && $stable(srwd));
endmodule

// File: rtl/spi_flash_write_guard.sv
module spi_flash_write_guard
  import wg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 16,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              eng_done,
  output logic              go,
  output logic [2:0]        go_op,
  output logic              rej,
  output logic              wel,
  output logic [BP_W-1:0]   bp,
  output logic              srwd,
  output logic              prot_any,
  output logic [ADDR_W-1:0] prot_base
);
  localparam int SR_BP_LSB = 2;
  localparam int SR_LOCK   = 7;

  wg_op_e op;
  logic   addr_hit, is_mod, ok;
  logic   wel_set, wel_clr, sr_load;
  logic   unused_sr_bits;

  assign op             = wg_op_e'(cmd_op);
  assign unused_sr_bits = ^{cmd_data[1:0], cmd_data[6:5]};

  wg_prot_decode #(.ADDR_W(ADDR_W), .BP_W(BP_W)) u_dec (
    .bp        (bp),
    .addr      (cmd_addr),
    .prot_any  (prot_any),
    .prot_base (prot_base),
    .addr_hit  (addr_hit)
  );

  wg_cmd_check #(.CNT_W(CNT_W)) u_chk (
    .op       (op),
    .bits     (cmd_bits),
    .wel      (wel),
    .srwd     (srwd),
    .wp_n     (wp_n),
    .addr_hit (addr_hit),
    .bp_nz    (bp != '0),
    .is_mod   (is_mod),
    .ok       (ok)
  );

  assign wel_set = cmd_valid && (op == OP_WREN);
  assign sr_load = cmd_valid && ok && (op == OP_WRSR);
  assign wel_clr = (cmd_valid && (op == OP_WRDI)) || sr_load || eng_done;

  wg_status_regs #(.BP_W(BP_W)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wel_set (wel_set),
    .wel_clr (wel_clr),
    .sr_load (sr_load),
    .bp_in   (cmd_data[SR_BP_LSB +: BP_W]),
    .srwd_in (cmd_data[SR_LOCK]),
    .wel     (wel),
    .bp      (bp),
    .srwd    (srwd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go    <= 1'b0;
      rej   <= 1'b0;
      go_op <= 3'd0;
    end else begin
      go  <= cmd_valid && ok;
      rej <= cmd_valid && is_mod && !ok;
      if (cmd_valid && ok) go_op <= cmd_op;
    end
  end

  // R11: start and reject are exclusive
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(go && rej));
  // R3: no latch, no start
  p_need_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_mod && !wel |=> rej && !go);
  // R4: partial byte is refused
  p_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_mod && (cmd_bits[2:0] != 3'd0) |=> rej);
  // R6: protected address is refused
  p_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (op == OP_PP || op == OP_SE) && prot_any && (cmd_addr >= prot_base) |=> rej);
  // R7: bulk erase needs no protection at all
  p_bulk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (op == OP_BE) && (bp != '0) |=> rej);
  // R8: hardware lock keeps status
  p_hwlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (op == OP_WRSR) && srwd && !wp_n |=> $stable(bp) && $stable(srwd) && rej);
  // R12: inert ops raise nothing
  p_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (op == OP_NOP || op == OP_READ) |=> !go && !rej);
endmodule

// File: tb/spi_flash_write_guard_bench.sv
module spi_flash_write_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [18:0] cmd_addr = '0;
  logic [15:0] cmd_bits = '0;
  logic [7:0]  cmd_data = '0;
  logic        wp_n = 1'b1;
  logic        eng_done = 1'b0;
  logic        go, rej, wel, srwd, prot_any;
  logic [2:0]  go_op, bp;
  logic [18:0] prot_base;

  int n_chk = 0;
  int n_fail = 0;
  bit m_wel = 0;
  bit m_srwd = 0;
  logic [2:0] m_bp = 3'd0;

  always #2.5 clk = ~clk;

  spi_flash_write_guard u_spi_flash_write_guard (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_addr, .cmd_bits, .cmd_data,
    .wp_n, .eng_done, .go, .go_op, .rej, .wel, .bp, .srwd, .prot_any, .prot_base
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_base(logic [2:0] c);
    case (c)
      3'd1: return 32'h70000;
      3'd2: return 32'h60000;
      3'd3: return 32'h40000;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_prot(logic [2:0] c, logic [18:0] a);
    if (c == 3'd0) return 0;
    return int'(a) >= exp_base(c);
  endfunction

  function automatic bit exp_ok(logic [2:0] op, logic [18:0] a, logic [15:0] b, bit wp);
    bit bytes = (b != 0) && (b[2:0] == 0);
    case (op)
      3'd3: return m_wel && bytes && !(m_srwd && !wp);
      3'd4, 3'd5: return m_wel && bytes && !is_prot(m_bp, a);
      3'd6: return m_wel && bytes && (m_bp == 0);
      default: return 0;
    endcase
  endfunction

  task automatic issue(string tag, logic [2:0] op, logic [18:0] a, logic [15:0] b,
                       logic [7:0] d, bit wp);
    bit ok, modi;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_bits = b; cmd_data = d; wp_n = wp;
    ok = exp_ok(op, a, b, wp);
    modi = (op >= 3'd3) && (op <= 3'd6);
    @(negedge clk);
    cmd_valid = 0;
    if (op == 3'd1) m_wel = 1;
    else if (op == 3'd2) m_wel = 0;
    else if (ok && op == 3'd3) begin m_wel = 0; m_bp = d[4:2]; m_srwd = d[7]; end
    check(tag, "go", int'(go), int'(ok));
    check(tag, "rej", int'(rej), int'(modi && !ok));
    if (ok) check(tag, "go_op", int'(go_op), int'(op));
    check(tag, "wel", int'(wel), int'(m_wel));
    check(tag, "bp", int'(bp), int'(m_bp));
    check(tag, "srwd", int'(srwd), int'(m_srwd));
  endtask

  task automatic done_pulse(string tag);
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0; m_wel = 0;
    check(tag, "wel after done", int'(wel), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [18:0] edges [6];
    edges = '{19'h3FFFF, 19'h40000, 19'h5FFFF, 19'h60000, 19'h6FFFF, 19'h70000};
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "wel", int'(wel), 0);
    check("R1", "bp", int'(bp), 0);
    check("R1", "srwd", int'(srwd), 0);
    check("R1", "go", int'(go), 0);
    check("R1", "rej", int'(rej), 0);
    check("R1", "prot_any", int'(prot_any), 0);
    rst_n = 1;
    // R2 latch control
    issue("R2", 3'd1, 0, 8, 0, 1);
    issue("R2", 3'd2, 0, 8, 0, 1);
    // R3 no latch
    issue("R3", 3'd4, 19'h100, 32, 0, 1);
    issue("R3", 3'd3, 0, 16, 8'h1C, 1);
    // R4 bit counts
    issue("R2", 3'd1, 0, 8, 0, 1);
    issue("R4", 3'd5, 19'h100, 33, 0, 1);
    issue("R4", 3'd6, 0, 0, 0, 1);
    issue("R4", 3'd3, 0, 15, 8'h04, 1);
    // R12 inert ops
    issue("R12", 3'd7, 19'h70000, 40, 0, 1);
    issue("R12", 3'd0, 0, 8, 8'hFF, 1);
    // R10 latch held until completion
    issue("R10", 3'd4, 19'h00010, 40, 0, 1);
    check("R10", "wel held", int'(wel), 1);
    done_pulse("R10");
    // R5 R6 sweep of codes against boundary addresses
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 6; k++) begin
        issue("R2", 3'd1, 0, 8, 0, 1);
        issue("R9", 3'd3, 0, 16, 8'(c << 2), 1);
        check("R5", "prot_any", int'(prot_any), int'(c != 0));
        check("R5", "prot_base", int'(prot_base), exp_base(3'(c)));
        issue("R2", 3'd1, 0, 8, 0, 1);
        issue("R6", (k % 2) ? 3'd5 : 3'd4, edges[k], 40, 0, 1);
        if (m_wel) done_pulse("R10");
        // R7 bulk erase
        issue("R2", 3'd1, 0, 8, 0, 1);
        issue("R7", 3'd6, 0, 8, 0, 1);
        if (m_wel) done_pulse("R10");
      end
    end
    // R8 hardware lock
    issue("R2", 3'd1, 0, 8, 0, 1);
    issue("R9", 3'd3, 0, 16, 8'h84, 1);
    issue("R2", 3'd1, 0, 8, 0, 1);
    issue("R8", 3'd3, 0, 16, 8'h00, 0);
    issue("R8", 3'd3, 0, 16, 8'h00, 1);
    // random mix, R11
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [15:0] b;
      logic [18:0] a;
      op = ($urandom_range(0, 3) == 0) ? 3'd1 : 3'($urandom_range(0, 7));
      b = ($urandom_range(0, 4) == 0) ? 16'($urandom_range(0, 63)) : 16'(8 * $urandom_range(1, 40));
      a = ($urandom_range(0, 1) == 0) ? edges[$urandom_range(0, 5)] : 19'($urandom);
      issue("R11", op, a, b, 8'($urandom), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 5) == 0) done_pulse("R10");
    end
    finish_up();
  end
endmodule